// File: doc/BRIEF.md
# Inbound Linked-Descriptor DMA Engine

This block moves a byte stream from a peripheral into memory under the control of a chain of four-word data descriptors. Each descriptor names a buffer start, a buffer end, a link to the next descriptor and a flags word. The engine fills the current buffer one byte per accepted beat. It closes the descriptor when the buffer is full or when the source marks the end of a packet. On each close it writes the true end address and the packet flag back into the descriptor and raises interrupt events. It then follows the link, or it stops at the end of the list and marks the owning context disabled.

Software builds the chain in memory and pulses `start` with the first descriptor address and the context address. The engine then runs by itself until it meets a descriptor whose end-of-list flag is set. Descriptor layout, byte offsets from the descriptor base:
- +0: next descriptor address.
- +4: buffer start.
- +8: flags. Bit 0 is end-of-list, bit 4 asks for an interrupt on close, and bit 11 is written by the engine when a packet end closed the descriptor.
- +12: buffer end, exclusive.

The memory port takes one access per cycle and returns read data one cycle after the read is issued. The stream input is valid/ready. A beat is transferred in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high only while a descriptor is open; the source must hold a beat stable until it is taken.

Top module: `dma_inbound_engine`

## Requirements
- R1: After reset, and whenever the list has ended, `at_eol` is 1, `s_ready` is 0 and no memory access is made. `start` is acted on only in this state.
- R2: Accepted bytes are written one per beat to consecutive byte addresses starting at the buffer start, with exactly one write-strobe bit set (the one selected by address bits 1:0). Bytes beyond the end are never written.
- R3: A descriptor closes on the beat that fills its buffer or on a beat with `s_last` set, and that beat's byte is stored.
- R4: A descriptor whose start equals its end closes on the first offered beat. That beat is consumed and its byte dropped. If the beat carries `s_last`, the packet end is recorded on this descriptor and is not carried into the next one.
- R5: On close, the word at +12 is overwritten with the address one past the last stored byte.
- R6: On close, the word at +8 is rewritten with all bits kept, and bit 11 is set exactly when `s_last` closed it.
- R7: On close, flags bit 4 sets raw interrupt bits 0 and 1, and `s_last` sets raw bit 3. `irq` is the OR of raw bits ANDed with `irq_mask`.
- R8: `irq_ack` clears the raw bits it names. A bit being set in the same cycle stays set.
- R9: When a descriptor with flags bit 0 closes, the engine writes bit 15 of the word at context +4, strobing only byte 1, and then returns to the end-of-list state.
- R10: Otherwise the engine fetches the descriptor at +0 and continues in its buffer. `s_ready` stays 0 during write-back and fetch.
- R11: A `start` pulse while a list is running has no effect on the running list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a list (honoured only at end of list) |
| start_desc | input | 32 | Address of the first descriptor |
| ctx_addr | input | 32 | Address of the owning context |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Beat ends a packet |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address (word aligned for word accesses) |
| mem_wdata | output | 32 | Write data |
| mem_wstrb | output | 4 | Byte write strobes |
| mem_rdata | input | 32 | Read data, one cycle after the read |
| irq_mask | input | 4 | Interrupt enable per raw bit |
| irq_ack | input | 4 | Clear pulse per raw bit |
| irq | output | 1 | Interrupt request |
| at_eol | output | 1 | Engine is at end of list |

## Verification
The close of a descriptor sets raw interrupt bits in the same clock edge at which software may be acknowledging earlier events. The bench first leaves raw bit 3 pending from a packet-end close. It then holds `irq_ack` at all ones through the beat that fills an interrupt-flagged buffer. Probing with single-bit masks afterwards must show bits 0 and 1 set and bit 3 cleared.

// File: rtl/dmai_pkg.sv
package dmai_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RUN,
    ST_WB,
    ST_CTX
  } dmai_state_e;

  localparam int FL_EOL   = 0;
  localparam int FL_INTR  = 4;
  localparam int FL_INEOP = 11;
  localparam int CTX_DIS  = 15;
  localparam int RAW_W    = 4;
  localparam int DESC_WORDS = 4;
endpackage

// File: rtl/dmai_irq.sv
module dmai_irq
  import dmai_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAW_W-1:0] set_bits,
  input  logic [RAW_W-1:0] ack,
  input  logic [RAW_W-1:0] mask,
  output logic             irq
);
  logic [RAW_W-1:0] raw;

  always_ff @(posedge clk) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~ack) | set_bits;
  end

  assign irq = |(raw & mask);

  // R8: a bit set in a cycle survives an acknowledge in the same cycle
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_bits) |=> ((raw & $past(set_bits)) == $past(set_bits)));

  // R8: acknowledged bits that were not being set are gone next cycle
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & ~set_bits)) |=> ((raw & $past(ack & ~set_bits)) == '0));
endmodule

// File: rtl/dmai_ctrl.sv
module dmai_ctrl
  import dmai_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    start_desc,
  input  logic [AW-1:0]    ctx_addr,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [DW/8-1:0]  mem_wstrb,
  input  logic [DW-1:0]    mem_rdata,
  output logic [RAW_W-1:0] set_bits,
  output logic             at_eol
);
  localparam int SW  = DW / 8;
  localparam int IXW = $clog2(DESC_WORDS + 1);
  localparam int LSB = $clog2(SW);

  dmai_state_e    st;
  logic [IXW-1:0] idx;
  logic [AW-1:0]  desc, ctxa, nxt, bufp, after, ptr;
  logic [DW-1:0]  flags;
  logic           eop_r, wbi;
  logic           beat, zero, close;

  assign s_ready = (st == ST_RUN);
  assign at_eol  = (st == ST_IDLE);
  assign beat    = s_valid && s_ready;
  assign zero    = (ptr == after);
  assign close   = beat && (zero || s_last || ((ptr + AW'(1)) == after));

  assign set_bits = {RAW_W{close}} &
                    {s_last, 1'b0, flags[FL_INTR], flags[FL_INTR]};

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wstrb = '0;
    unique case (st)
      ST_FETCH: begin
        mem_en   = (idx != IXW'(DESC_WORDS));
        mem_addr = desc + AW'({idx, {LSB{1'b0}}});
      end
      ST_RUN: begin
        if (beat && !zero) begin
          mem_en    = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = ptr;
          mem_wdata = {SW{s_data}};
          mem_wstrb = SW'(1) << ptr[LSB-1:0];
        end
      end
      ST_WB: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wstrb = '1;
        if (!wbi) begin
          mem_addr  = desc + AW'(2 * SW);
          mem_wdata = flags | (DW'(eop_r) << FL_INEOP);
        end else begin
          mem_addr  = desc + AW'(3 * SW);
          mem_wdata = DW'(ptr);
        end
      end
      ST_CTX: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = ctxa + AW'(SW);
        mem_wdata = DW'(1) << CTX_DIS;
        mem_wstrb = SW'(1) << (CTX_DIS / 8);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx   <= '0;
      desc  <= '0;
      ctxa  <= '0;
      nxt   <= '0;
      bufp  <= '0;
      after <= '0;
      ptr   <= '0;
      flags <= '0;
      eop_r <= 1'b0;
      wbi   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          desc <= start_desc;
          ctxa <= ctx_addr;
          idx  <= '0;
          st   <= ST_FETCH;
        end
        ST_FETCH: begin
          idx <= idx + IXW'(1);
          unique case (idx)
            IXW'(1): nxt   <= mem_rdata[AW-1:0];
            IXW'(2): bufp  <= mem_rdata[AW-1:0];
            IXW'(3): flags <= mem_rdata;
            IXW'(4): begin
              after <= mem_rdata[AW-1:0];
              ptr   <= bufp;
              st    <= ST_RUN;
            end
            default: ;
          endcase
        end
        ST_RUN: if (beat) begin
          if (!zero) ptr <= ptr + AW'(1);
          if (close) begin
            eop_r <= s_last;
            wbi   <= 1'b0;
            st    <= ST_WB;
          end
        end
        ST_WB: begin
          wbi <= 1'b1;
          if (wbi) begin
            if (flags[FL_EOL]) st <= ST_CTX;
            else begin
              desc <= nxt;
              idx  <= '0;
              st   <= ST_FETCH;
            end
          end
        end
        ST_CTX: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: nothing accepted and no memory traffic at end of list
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    at_eol |-> (!s_ready && !mem_en));

  // R2: every stored stream byte uses a single strobe and a live beat
  p_byte_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && s_ready) |-> ($onehot(mem_wstrb) && s_valid));

  // R6: a close is followed at once by the flags write-back
  p_close_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> (mem_we && mem_addr == $past(desc) + AW'(2 * SW) &&
               mem_wdata[FL_INEOP] == ($past(s_last) || $past(flags[FL_INEOP]))));

  // R10: no beat is taken in the cycle after a close
  p_stall_after_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> !s_ready);
endmodule

// File: rtl/dma_inbound_engine.sv
module dma_inbound_engine
  import dmai_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   start_desc,
  input  logic [AW-1:0]   ctx_addr,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [7:0]      s_data,
  input  logic            s_last,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic [DW/8-1:0] mem_wstrb,
  input  logic [DW-1:0]   mem_rdata,
  input  logic [3:0]      irq_mask,
  input  logic [3:0]      irq_ack,
  output logic            irq,
  output logic            at_eol
);
  logic [RAW_W-1:0] set_bits;

  dmai_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_desc (start_desc),
    .ctx_addr   (ctx_addr),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .s_data     (s_data),
    .s_last     (s_last),
    .mem_en     (mem_en),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_wstrb  (mem_wstrb),
    .mem_rdata  (mem_rdata),
    .set_bits   (set_bits),
    .at_eol     (at_eol)
  );

  dmai_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (set_bits),
    .ack      (irq_ack),
    .mask     (irq_mask),
    .irq      (irq)
  );
endmodule

// File: tb/test_dma_inbound_engine.sv
module test_dma_inbound_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_desc = '0, ctx_addr = '0;
  logic        s_valid = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready, mem_en, mem_we, irq, at_eol;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_wstrb;
  logic [3:0]  irq_mask = 4'hF, irq_ack = 4'h0;

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] mem [0:1023];

  always #4 clk = ~clk;

  dma_inbound_engine i_dma_inbound_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_desc(start_desc),
    .ctx_addr(ctx_addr), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_rdata(mem_rdata), .irq_mask(irq_mask), .irq_ack(irq_ack),
    .irq(irq), .at_eol(at_eol)
  );

  // memory model: one-cycle read latency, byte strobes on write
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_wstrb[b]) mem[{mem_addr[9:2], 2'(b)}] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= {mem[{mem_addr[9:2], 2'd3}], mem[{mem_addr[9:2], 2'd2}],
                      mem[{mem_addr[9:2], 2'd1}], mem[{mem_addr[9:2], 2'd0}]};
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 60000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr32(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a + b] = v[8*b +: 8];
  endtask

  function automatic logic [31:0] rd32(input int a);
    return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
  endfunction

  task automatic mk_desc(input int a, input int nx, input int bf,
                         input logic [31:0] fl, input int af);
    wr32(a, nx); wr32(a + 4, bf); wr32(a + 8, fl); wr32(a + 12, af);
  endtask

  task automatic kick(input int d);
    @(negedge clk);
    start = 1'b1; start_desc = d; ctx_addr = 32'h180;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic l, input logic [3:0] ak);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_last = l; irq_ack = ak;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    #1;
    s_valid = 1'b0; s_last = 1'b0; irq_ack = 4'h0;
  endtask

  task automatic wait_eol(input string req);
    int n = 0;
    @(negedge clk);
    while (!at_eol && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(at_eol, req, at_eol, 1);
  endtask

  task automatic probe_raw(input logic [3:0] exp, input string req);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      irq_mask = 4'(1 << b);
      #1;
      check(irq == exp[b], req, irq, exp[b]);
    end
    @(negedge clk);
    irq_mask = 4'hF;
  endtask

  task automatic ack_all;
    @(negedge clk); irq_ack = 4'hF;
    @(negedge clk); irq_ack = 4'h0;
  endtask

  // vector: [15:8] buffer length, [7:4] bytes offered, [1] last on final byte, [0] intr flag
  localparam logic [15:0] VEC [6] = '{
    16'h0881, 16'h0832, 16'h0443, 16'h1013, 16'h0012, 16'h0011
  };

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(at_eol == 1'b1, "R1 at_eol after reset", at_eol, 1);
    check(s_ready == 1'b0, "R1 s_ready after reset", s_ready, 0);
    check(mem_en == 1'b0, "R1 no memory access after reset", mem_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R1 irq after reset", irq, 0);
    check(s_ready == 1'b0 && at_eol, "R1 idle without start", s_ready, 0);

    for (int v = 0; v < 6; v++) begin
      int blen = VEC[v][15:8];
      int n    = VEC[v][7:4];
      bit lst  = VEC[v][1];
      bit itr  = VEC[v][0];
      int wrn  = (blen == 0) ? 0 : n;
      logic [31:0] fl = 32'h00AB_0001 | (32'(itr) << 4);
      for (int i = 0; i < 32; i++) mem[32'h200 + i] = 8'hEE;
      mk_desc(32'h100, 0, 32'h200, fl, 32'h200 + blen);
      wr32(32'h184, 32'h0);
      kick(32'h100);
      for (int i = 0; i < n; i++) push(8'(8'h30 + v * 16 + i), lst && (i == n - 1), 4'h0);
      wait_eol("R9 list ends");
      // R5: end pointer written back
      check(rd32(32'h10C) == 32'h200 + wrn, "R5 after field", rd32(32'h10C), 32'h200 + wrn);
      // R6: flags kept, bit 11 iff packet end
      check(rd32(32'h108) == (fl | (32'(lst) << 11)), "R6 flags write-back",
            rd32(32'h108), fl | (32'(lst) << 11));
      // R2 / R3 / R4: stored bytes and untouched byte after them
      for (int i = 0; i < wrn; i++)
        check(mem[32'h200 + i] == 8'(8'h30 + v * 16 + i), "R2 stored byte",
              mem[32'h200 + i], 8'h30 + v * 16 + i);
      check(mem[32'h200 + wrn] == 8'hEE, "R4 no write past end", mem[32'h200 + wrn], 8'hEE);
      // R9: context disable bit only
      check(rd32(32'h184) == 32'h0000_8000, "R9 context disable", rd32(32'h184), 32'h8000);
      // R7: raw interrupt bits
      probe_raw({lst, 1'b0, itr, itr}, "R7 raw interrupt");
      ack_all();
      check(irq == 1'b0, "R8 ack clears", irq, 0);
    end

    // R8: collision of close-set with acknowledge
    mk_desc(32'h100, 0, 32'h200, 32'h1, 32'h208);
    kick(32'h100);
    push(8'h11, 1'b0, 4'h0);
    push(8'h12, 1'b1, 4'h0);
    wait_eol("R8 setup ends");
    mk_desc(32'h100, 0, 32'h200, 32'h11, 32'h202);
    kick(32'h100);
    push(8'h21, 1'b0, 4'h0);
    push(8'h22, 1'b0, 4'hF);
    wait_eol("R8 collision ends");
    probe_raw(4'b0011, "R8 set wins over ack");
    ack_all();

    // R10 / R11: chained list with a stray start mid-run
    for (int i = 0; i < 16; i++) mem[32'h280 + i] = 8'hEE;
    mk_desc(32'h100, 32'h120, 32'h200, 32'h0, 32'h204);
    mk_desc(32'h120, 32'h000, 32'h280, 32'h1, 32'h288);
    wr32(32'h184, 32'h0);
    kick(32'h100);
    push(8'h50, 1'b0, 4'h0);
    @(negedge clk);
    start = 1'b1; start_desc = 32'h140;
    @(negedge clk);
    start = 1'b0;
    push(8'h51, 1'b0, 4'h0);
    push(8'h52, 1'b0, 4'h0);
    push(8'h53, 1'b0, 4'h0);
    @(negedge clk);
    check(s_ready == 1'b0, "R10 stalled during write-back", s_ready, 0);
    push(8'h60, 1'b0, 4'h0);
    push(8'h61, 1'b1, 4'h0);
    wait_eol("R10 chain ends");
    check(rd32(32'h10C) == 32'h204, "R10 first after", rd32(32'h10C), 32'h204);
    check(rd32(32'h108) == 32'h0, "R6 first flags no packet end", rd32(32'h108), 0);
    check(rd32(32'h12C) == 32'h282, "R11 second after", rd32(32'h12C), 32'h282);
    check(rd32(32'h128) == 32'h801, "R10 second flags", rd32(32'h128), 32'h801);
    check(mem[32'h281] == 8'h61 && mem[32'h282] == 8'hEE, "R10 second buffer",
          mem[32'h281], 8'h61);
    check(rd32(32'h140) == 32'h0 && mem[32'h203] == 8'h53, "R11 stray start ignored",
          mem[32'h203], 8'h53);
    probe_raw(4'b1000, "R7 chain raw");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule